// File: doc/BRIEF.md
# Compare-Value Timer Pair with Virtual Offset

This block holds two 64-bit compare-value timers that watch a free-running 64-bit system count. The physical timer compares the count as it is. The virtual timer first subtracts a programmable 64-bit offset from the count, modulo 2^64, and compares that result. Each timer has a compare-value register, a control register and a registered interrupt line. Software reaches all registers through one flat write/read port.

A timer fires when its compare value is at or below its own view of the count, using an unsigned comparison. The offset is never added to the compare value. Because of that, a compare value near the top of the range cannot overflow into a false match. Status also drops again at the point where the virtual view wraps through zero. With a nonzero offset, that point comes long before the physical count wraps.

Top module: `vtimer_pair`

## Requirements
- R1: The physical timer's count view equals `count_i`. The virtual timer's view equals `count_i - offset` modulo 2^64.
- R2: A timer's condition holds when its compare value is less than or equal to its count view, both taken as unsigned 64-bit numbers.
- R3: The status bit reads as 0 while the timer's enable bit is clear. This holds whatever the condition is.
- R4: An interrupt output is high only if the condition holds, enable is set and mask is clear. It is registered, so it follows the state of the previous cycle.
- R5: When the virtual compare value is all ones and the offset is nonzero, the virtual interrupt stays low for every count whose view is not all ones.
- R6: Once status is true, it drops to false in the cycle where the virtual view wraps to zero (`count_i == offset`). For this the compare value must be nonzero.
- R7: A register write takes effect from the next clock edge. Status read after that edge reflects the new value with no stale state.
- R8: Control register layout: bit 0 is enable and bit 1 is mask. Bit 2 is status and is read-only: a write to it has no effect. All other bits read as 0.
- R9: After reset, every register reads 0 and both interrupts are low.
- R10: Address map for `addr_i`: 0 is the physical compare value, 1 the physical control, 2 the virtual compare value, 3 the virtual control, 4 the offset. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 64 | Free-running system count |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i`, combinational |
| phys_irq_o | output | 1 | Physical timer interrupt |
| virt_irq_o | output | 1 | Virtual timer interrupt |

## Verification
Two things can happen in the same cycle: an offset write and the count moving across the virtual wrap point. The bench places the count one step below the current offset. It then writes a new offset and advances the count on the same edge. The read-back status and the interrupt one cycle later are compared with a 65-bit reference model that uses only the new offset. A seeded sweep then mixes offset, compare-value and count patterns, and each one is judged by the same model.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;
    localparam int CNT_W   = 64;
    localparam int ADDR_W  = 3;
    localparam int N_TMR   = 2;
    localparam int TMR_PHY = 0;
    localparam int TMR_VIR = 1;

    localparam logic [ADDR_W-1:0] A_OFFSET = 3'd4;

    localparam int CTL_EN   = 0;
    localparam int CTL_MASK = 1;
    localparam int CTL_STAT = 2;

    function automatic logic [ADDR_W-1:0] cval_addr(input int idx);
        return ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
        return ADDR_W'(2 * idx + 1);
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0] cval;
        logic             en;
        logic             mask;
        logic             irq;
    } tmr_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] off;
    } top_state_t;
endpackage

// File: rtl/vtimer_cmp.sv
module vtimer_cmp
    import vtimer_pkg::*;
(
    input  logic [CNT_W-1:0] view_i,
    input  logic [CNT_W-1:0] cval_i,
    output logic             hit_o
);
    always_comb begin
        hit_o = (view_i >= cval_i);
    end

    // R5: an all-ones compare value matches only an all-ones view
    always_comb begin
        if (cval_i == '1 && view_i != '1) begin
            a_r5_no_overflow_hit: assert (!hit_o);
        end
    end

    // R6: a view at zero never meets a nonzero compare value
    always_comb begin
        if (view_i == '0 && cval_i != '0) begin
            a_r6_wrap_release: assert (!hit_o);
        end
    end
endmodule

// File: rtl/vtimer_chan.sv
module vtimer_chan
    import vtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cval_i,
    input  logic             wr_ctl_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] view_i,
    output logic [CNT_W-1:0] cval_o,
    output logic             en_o,
    output logic             mask_o,
    output logic             stat_o,
    output logic             irq_o
);
    tmr_state_t st_d, st_q;
    logic       hit;

    vtimer_cmp u_cmp (
        .view_i (view_i),
        .cval_i (st_q.cval),
        .hit_o  (hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_cval_i) begin
            st_d.cval = wdata_i;
        end
        if (wr_ctl_i) begin
            st_d.en   = wdata_i[CTL_EN];
            st_d.mask = wdata_i[CTL_MASK];
        end
        st_d.irq = hit && st_q.en && !st_q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cval_o = st_q.cval;
    assign en_o   = st_q.en;
    assign mask_o = st_q.mask;
    assign stat_o = hit && st_q.en;
    assign irq_o  = st_q.irq;

    // R4: a raised interrupt implies an unmasked, enabled match one cycle earlier
    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_o && !mask_o && stat_o));

    // R4: a masked timer drops its interrupt on the next edge
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o |=> !irq_o);
endmodule

// File: rtl/vtimer_pair.sv
module vtimer_pair
    import vtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       count_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [63:0]       wdata_i,
    output logic [63:0]       rdata_o,
    output logic              phys_irq_o,
    output logic              virt_irq_o
);
    top_state_t top_d, top_q;

    logic [CNT_W-1:0] view   [N_TMR];
    logic [CNT_W-1:0] cval   [N_TMR];
    logic             en     [N_TMR];
    logic             mask   [N_TMR];
    logic             stat   [N_TMR];
    logic             irq    [N_TMR];

    always_comb begin
        top_d = top_q;
        if (wr_en_i && addr_i == A_OFFSET) begin
            top_d.off = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        if (g == TMR_VIR) begin : g_view
            assign view[g] = count_i - top_q.off;
        end else begin : g_view
            assign view[g] = count_i;
        end

        vtimer_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cval_i (wr_en_i && addr_i == cval_addr(g)),
            .wr_ctl_i  (wr_en_i && addr_i == ctl_addr(g)),
            .wdata_i   (wdata_i),
            .view_i    (view[g]),
            .cval_o    (cval[g]),
            .en_o      (en[g]),
            .mask_o    (mask[g]),
            .stat_o    (stat[g]),
            .irq_o     (irq[g])
        );
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (addr_i == cval_addr(i)) begin
                rdata_o = cval[i];
            end
            if (addr_i == ctl_addr(i)) begin
                rdata_o[CTL_EN]   = en[i];
                rdata_o[CTL_MASK] = mask[i];
                rdata_o[CTL_STAT] = stat[i];
            end
        end
        if (addr_i == A_OFFSET) begin
            rdata_o = top_q.off;
        end
    end

    assign phys_irq_o = irq[TMR_PHY];
    assign virt_irq_o = irq[TMR_VIR];

    // R3: status read back is zero while the virtual timer is disabled
    a_r3_stat_off: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ctl_addr(TMR_VIR) && !en[TMR_VIR]) |-> !rdata_o[CTL_STAT]);

    // R10: a write to an unmapped address leaves the offset unchanged
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i > A_OFFSET) |=> $stable(top_q.off));
endmodule

// File: tb/tb_vtimer_pair.sv
`timescale 1ns/1ps
module tb_vtimer_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        phys_irq, virt_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vtimer_pair dut (
        .clk(clk), .rst_n(rst_n), .count_i(count), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .phys_irq_o(phys_irq), .virt_irq_o(virt_irq)
    );

    function automatic bit ref_hit(input logic [63:0] cnt, input logic [63:0] off,
                                   input logic [63:0] cv);
        logic [64:0] v;
        v = {1'b1, cnt} - {1'b0, off};
        return {1'b0, v[63:0]} >= {1'b0, cv};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic set_cnt(input logic [63:0] c);
        @(negedge clk);
        count = c;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R9 reg reset", d, 64'd0);
        end
        chk("R9 phys irq reset", {63'd0, phys_irq}, 64'd0);
        chk("R9 virt irq reset", {63'd0, virt_irq}, 64'd0);
    endtask

    task automatic t_phys();
        logic [63:0] d;
        wr(3'd0, 64'd100);
        wr(3'd1, 64'd1);
        set_cnt(64'd99);
        settle();
        rd(3'd1, d);
        chk("R2 below cval", d, 64'd1);
        chk("R4 irq low below", {63'd0, phys_irq}, 64'd0);
        set_cnt(64'd100);
        rd(3'd1, d);
        chk("R2 equal cval", d, 64'd5);
        chk("R4 irq one cycle late", {63'd0, phys_irq}, 64'd0);
        @(negedge clk);
        chk("R4 irq raised", {63'd0, phys_irq}, 64'd1);
        wr(3'd1, 64'd3);
        @(negedge clk);
        chk("R4 mask blocks irq", {63'd0, phys_irq}, 64'd0);
        rd(3'd1, d);
        chk("R8 masked ctrl read", d, 64'd7);
        wr(3'd1, 64'd0);
        rd(3'd1, d);
        chk("R3 status hidden when off", d, 64'd0);
        settle();
        chk("R4 disabled irq low", {63'd0, phys_irq}, 64'd0);
    endtask

    task automatic t_ro_stat();
        logic [63:0] d;
        set_cnt(64'd10);
        wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFC);
        rd(3'd1, d);
        chk("R8 status write ignored", d, 64'd0);
        wr(3'd1, 64'd5);
        rd(3'd1, d);
        chk("R8 status not forced", d, 64'd1);
        wr(3'd1, 64'd0);
    endtask

    task automatic t_allones();
        logic [63:0] d;
        logic [63:0] cnts [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'd5,
                                  64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE};
        wr(3'd4, 64'd1);
        wr(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(3'd3, 64'd1);
        foreach (cnts[i]) begin
            set_cnt(cnts[i]);
            settle();
            chk("R5 no false virt irq", {63'd0, virt_irq}, 64'd0);
        end
        set_cnt(64'd0);
        rd(3'd3, d);
        chk("R5 all-ones view matches", d, 64'd5);
        settle();
        chk("R5 irq at all-ones view", {63'd0, virt_irq}, 64'd1);
    endtask

    task automatic t_wrap();
        logic [63:0] d;
        logic [63:0] offs [3] = '{64'd1, 64'd1000, 64'h8000_0000_0000_0000};
        wr(3'd2, 64'd10);
        wr(3'd3, 64'd1);
        foreach (offs[i]) begin
            wr(3'd4, offs[i]);
            rd(3'd4, d);
            chk("R10 offset readback", d, offs[i]);
            set_cnt(offs[i] - 64'd1);
            rd(3'd3, d);
            chk("R1 view all ones fires", d[2], ref_hit(count, offs[i], 64'd10));
            set_cnt(offs[i]);
            rd(3'd3, d);
            chk("R6 release at view zero", d, 64'd1);
            settle();
            chk("R6 irq released", {63'd0, virt_irq}, 64'd0);
            set_cnt(offs[i] + 64'd10);
            rd(3'd3, d);
            chk("R1 view reaches cval", d, 64'd5);
        end
    endtask

    task automatic t_same_cycle();
        logic [63:0] d;
        wr(3'd4, 64'd500);
        wr(3'd2, 64'd3);
        wr(3'd3, 64'd1);
        set_cnt(64'd499);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 64'd200; count = 64'd200;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd3, d);
        chk("R7 new offset used at once", d[2], ref_hit(64'd200, 64'd200, 64'd3));
        @(negedge clk);
        chk("R7 irq from new offset", {63'd0, virt_irq}, 64'd0);
        set_cnt(64'd203);
        rd(3'd3, d);
        chk("R7 status after rewrite", d[2], ref_hit(64'd203, 64'd200, 64'd3));
    endtask

    task automatic t_unmapped();
        logic [63:0] d;
        wr(3'd5, 64'hDEAD);
        wr(3'd6, 64'hBEEF);
        wr(3'd7, 64'h1234);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d);
            chk("R10 unmapped reads zero", d, 64'd0);
        end
        rd(3'd4, d);
        chk("R10 offset untouched", d, 64'd200);
        rd(3'd0, d);
        chk("R10 phys cval untouched", d, 64'd100);
    endtask

    task automatic t_sweep();
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        logic [63:0] off, cv, c, d;
        wr(3'd1, 64'd1);
        for (int i = 0; i < 40; i++) begin
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            off = (i % 4 == 0) ? 64'd0 : s;
            cv  = (i % 5 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {s[31:0], s[63:32]};
            c   = (i % 3 == 0) ? off + cv : s ^ 64'h5555;
            wr(3'd4, off);
            wr(3'd2, cv);
            wr(3'd0, cv);
            set_cnt(c);
            rd(3'd3, d);
            chk("R2 virt sweep", d[2], ref_hit(c, off, cv));
            rd(3'd1, d);
            chk("R1 phys sweep", d[2], ref_hit(c, 64'd0, cv));
            settle();
            chk("R4 virt irq sweep", {63'd0, virt_irq}, {63'd0, ref_hit(c, off, cv)});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phys();
        t_ro_stat();
        t_allones();
        t_wrap();
        t_same_cycle();
        t_unmapped();
        t_sweep();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule